// File: doc/BRIEF.md
# Five-Phase Multicycle Accumulator CPU Core

This block is a small processor core that carries out one instruction at a time. Instructions and data share a single memory with one address bus, one read strobe and one write strobe. A hard-wired controller takes every instruction through the same ordered phases: fetch, decode, operand load, execute and store. Any phase that an instruction has no use for is skipped, so instructions of different kinds take different numbers of cycles. Peripheral ports live in a separate address space and have their own read and write strobes.

The core holds four 8-bit work registers, a program counter, an instruction register and a three-bit status register. A 16-bit instruction is fetched as two 8-bit memory words. Increment, add and subtract are offered in register, register-indirect, immediate and memory-direct forms, and each form has its own opcode. Two port instructions move a byte between a register and a peripheral port.

Top module: `mc_cpu_core`

## Requirements
- R1: While reset is held and after it is released, the program counter, the four registers and the status flags are zero, and no write strobe or port strobe is active. The first cycle after release fetches address 0.
- R2: An instruction takes two fetch cycles, which read addresses PC and PC+1 with mem_rd high. PC wraps modulo 64. The first byte fetched is bits [15:8]. The layout is opcode [15:10], register A [9:8], register B [7:6] and immediate/address/port [5:0].
- R3: One decode cycle follows the fetch. After it come load, execute and store, each lasting one cycle and each run only if the opcode needs it. The next fetch starts in the cycle after the last phase. Decode and execute drive no strobe.
- R4: Opcode 0 (no-op) and every opcode above 11 take only the fetch and decode cycles and change no register, flag or memory location.
- R5: Register forms: opcode 1 sets A=A+1, opcode 2 sets A=A+B, opcode 3 sets A=B−A. The result is written in the execute cycle.
- R6: Register-indirect forms read memory at the low 6 bits of register B in a load cycle. Opcode 4 then sets A=A+mem and opcode 5 sets A=mem−A.
- R7: Immediate forms take the 6-bit field zero-extended. Opcode 7 sets A=A+imm and opcode 8 sets A=imm−A.
- R8: Opcode 6 reads memory at the address field, adds 1 and writes the result back to the same address in a store cycle. Opcode 9 sets A=A+mem[address field].
- R9: flags_o is {V,C,Z} (bit 2 overflow, bit 1 carry, bit 0 zero). The flags change only at the end of an execute cycle. Z is set for a zero 8-bit result. C is the carry out for addition and the borrow for subtraction (minuend < subtrahend). V is set on signed two's-complement overflow.
- R10: Opcode 10 drives io_rd with io_addr set to the field for one load cycle and writes io_rdata into A. Opcode 11 drives io_wr with io_wdata=A for one store cycle. The memory strobes stay low during port cycles, and at most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 6 | Shared address for instruction and data memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational from mem_addr |
| io_addr | output | 6 | Port number |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, combinational from io_addr |
| flags_o | output | 3 | Status register {V,C,Z} |

## Verification
The two fetch cycles always come first. Decode follows one cycle later, and each phase the opcode needs then adds exactly one cycle. A bus strobe is therefore due in a cycle that can be known before it happens, and the flags of an execute cycle become visible in the cycle after it. A behavioural model in the bench expands each instruction into the list of cycles it should produce and tags each cycle with its requirement. At every falling edge the bench removes one entry from that list and compares it with the strobes, addresses, data and flags. Register results are seen at the ports through later port writes. Directed programs cover the flag corners and the undefined opcodes, and a second directed run after a reset shows that the registers were cleared.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_DECODE,
      PH_LOAD,
      PH_EXEC,
      PH_STORE
   } phase_e;

   typedef enum logic {
      ALU_ADD,
      ALU_SUB
   } alu_op_e;

   typedef enum logic [2:0] {
      SRC_RA,
      SRC_RB,
      SRC_MEM,
      SRC_IMM,
      SRC_ONE
   } src_e;

   localparam int OP_NOP     = 0;
   localparam int OP_INC_R   = 1;
   localparam int OP_ADD_R   = 2;
   localparam int OP_SUB_R   = 3;
   localparam int OP_ADD_IND = 4;
   localparam int OP_SUB_IND = 5;
   localparam int OP_INC_M   = 6;
   localparam int OP_ADD_K   = 7;
   localparam int OP_SUB_K   = 8;
   localparam int OP_ADD_M   = 9;
   localparam int OP_PORT_IN = 10;
   localparam int OP_PORT_OUT = 11;

   typedef struct packed {
      logic    ld_mem;
      logic    ld_rb;
      logic    ld_io;
      logic    ex;
      logic    wr_reg;
      logic    st_mem;
      logic    st_io;
      alu_op_e op;
      src_e    sa;
      src_e    sb;
   } ctl_t;

endpackage

// File: rtl/mc_cpu_decode.sv
module mc_cpu_decode
   import mc_cpu_pkg::*;
#(
   parameter int OPC_W = 6
) (
   input  logic [OPC_W-1:0] opc,
   output ctl_t             ctl
);

   always_comb begin
      ctl    = '0;
      ctl.op = ALU_ADD;
      ctl.sa = SRC_RA;
      ctl.sb = SRC_RB;
      case (opc)
         OPC_W'(OP_INC_R): begin
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.sb = SRC_ONE;
         end
         OPC_W'(OP_ADD_R): begin
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1;
         end
         OPC_W'(OP_SUB_R): begin
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.op = ALU_SUB;
            ctl.sa = SRC_RB; ctl.sb = SRC_RA;
         end
         OPC_W'(OP_ADD_IND): begin
            ctl.ld_mem = 1'b1; ctl.ld_rb = 1'b1;
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.sb = SRC_MEM;
         end
         OPC_W'(OP_SUB_IND): begin
            ctl.ld_mem = 1'b1; ctl.ld_rb = 1'b1;
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.op = ALU_SUB;
            ctl.sa = SRC_MEM; ctl.sb = SRC_RA;
         end
         OPC_W'(OP_INC_M): begin
            ctl.ld_mem = 1'b1; ctl.ex = 1'b1; ctl.st_mem = 1'b1;
            ctl.sa = SRC_MEM; ctl.sb = SRC_ONE;
         end
         OPC_W'(OP_ADD_K): begin
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.sb = SRC_IMM;
         end
         OPC_W'(OP_SUB_K): begin
            ctl.ex = 1'b1; ctl.wr_reg = 1'b1; ctl.op = ALU_SUB;
            ctl.sa = SRC_IMM; ctl.sb = SRC_RA;
         end
         OPC_W'(OP_ADD_M): begin
            ctl.ld_mem = 1'b1; ctl.ex = 1'b1; ctl.wr_reg = 1'b1;
            ctl.sb = SRC_MEM;
         end
         OPC_W'(OP_PORT_IN):  ctl.ld_io = 1'b1;
         OPC_W'(OP_PORT_OUT): ctl.st_io = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/mc_cpu_alu.sv
module mc_cpu_alu
   import mc_cpu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] res,
   output logic         z,
   output logic         c,
   output logic         v
);

   logic         sub;
   logic [W-1:0] bx;
   logic [W:0]   sum;

   always_comb begin
      sub = (op == ALU_SUB);
      bx  = sub ? ~b : b;
      sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
      res = sum[W-1:0];
      z   = (sum[W-1:0] == '0);
      c   = sub ? ~sum[W] : sum[W];
      v   = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
   end

endmodule

// File: rtl/mc_cpu_regfile.sv
module mc_cpu_regfile #(
   parameter int W     = 8,
   parameter int NREG  = 4,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic [SEL_W-1:0] ra_sel,
   input  logic [SEL_W-1:0] rb_sel,
   output logic [W-1:0]     ra_val,
   output logic [W-1:0]     rb_val
);

   logic [W-1:0] regs [NREG];

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[gi] <= '0;
         else if (we && (waddr == SEL_W'(gi)))
            regs[gi] <= wdata;
      end
   end

   assign ra_val = regs[ra_sel];
   assign rb_val = regs[rb_sel];

endmodule

// File: rtl/mc_cpu_ctrl.sv
module mc_cpu_ctrl
   import mc_cpu_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BEATS  = 2,
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              need_load,
   input  logic              need_exec,
   input  logic              need_store,
   output phase_e            phase,
   output logic [ADDR_W-1:0] pc
);

   phase_e            phase_q, phase_d;
   logic [ADDR_W-1:0] pc_q;
   logic [BEAT_W-1:0] beat_q;
   logic              last_beat;

   assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_FETCH:  if (last_beat) phase_d = PH_DECODE;
         PH_DECODE: phase_d = need_load  ? PH_LOAD :
                              need_exec  ? PH_EXEC :
                              need_store ? PH_STORE : PH_FETCH;
         PH_LOAD:   phase_d = need_exec  ? PH_EXEC :
                              need_store ? PH_STORE : PH_FETCH;
         PH_EXEC:   phase_d = need_store ? PH_STORE : PH_FETCH;
         default:   phase_d = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FETCH;
         pc_q    <= '0;
         beat_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_FETCH) begin
            pc_q   <= pc_q + ADDR_W'(1);
            beat_q <= last_beat ? '0 : beat_q + BEAT_W'(1);
         end
      end
   end

   assign phase = phase_q;
   assign pc    = pc_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FETCH) |=> (pc_q == $past(pc_q) + ADDR_W'(1))); // R2

   AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DECODE) |-> ($past(phase_q) == PH_FETCH)); // R3

endmodule

// File: rtl/mc_cpu_core.sv
module mc_cpu_core
   import mc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int NREG   = 4,
   parameter int OPC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] io_addr,
   output logic              io_rd,
   output logic              io_wr,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic [2:0]        flags_o
);

   localparam int SEL_W   = $clog2(NREG);
   localparam int IMM_W   = ADDR_W;
   localparam int INSTR_W = OPC_W + 2 * SEL_W + IMM_W;
   localparam int BEATS   = INSTR_W / DATA_W;

   if (INSTR_W % DATA_W != 0) begin : g_bad_width
      $error("instruction width must be a multiple of the data width");
   end
   if (DATA_W < ADDR_W) begin : g_bad_addr
      $error("data width must cover the address width");
   end
   if (NREG < 2 || (1 << SEL_W) != NREG) begin : g_bad_nreg
      $error("register count must be a power of two");
   end

   phase_e              phase;
   logic [ADDR_W-1:0]   pc;
   logic [INSTR_W-1:0]  ir_q;
   logic [DATA_W-1:0]   opnd_q, res_q;
   logic [2:0]          flags_q;
   ctl_t                ctl;

   logic [OPC_W-1:0]    opc;
   logic [SEL_W-1:0]    ra_sel, rb_sel;
   logic [IMM_W-1:0]    imm;
   logic [DATA_W-1:0]   ra_val, rb_val;
   logic [DATA_W-1:0]   alu_a, alu_b, alu_res;
   logic                alu_z, alu_c, alu_v;
   logic [ADDR_W-1:0]   ld_addr;
   logic                rf_we;
   logic [DATA_W-1:0]   rf_wdata;
   logic                in_load, in_exec, in_store;

   assign opc    = ir_q[INSTR_W-1 -: OPC_W];
   assign ra_sel = ir_q[IMM_W + SEL_W +: SEL_W];
   assign rb_sel = ir_q[IMM_W +: SEL_W];
   assign imm    = ir_q[IMM_W-1:0];

   assign in_load  = (phase == PH_LOAD);
   assign in_exec  = (phase == PH_EXEC);
   assign in_store = (phase == PH_STORE);

   mc_cpu_decode #(.OPC_W(OPC_W)) u_decode (
      .opc (opc),
      .ctl (ctl)
   );

   mc_cpu_ctrl #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .need_load  (ctl.ld_mem | ctl.ld_io),
      .need_exec  (ctl.ex),
      .need_store (ctl.st_mem | ctl.st_io),
      .phase      (phase),
      .pc         (pc)
   );

   mc_cpu_regfile #(.W(DATA_W), .NREG(NREG)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rf_we),
      .waddr  (ra_sel),
      .wdata  (rf_wdata),
      .ra_sel (ra_sel),
      .rb_sel (rb_sel),
      .ra_val (ra_val),
      .rb_val (rb_val)
   );

   function automatic logic [DATA_W-1:0] pick(src_e s, logic [DATA_W-1:0] ra,
                                              logic [DATA_W-1:0] rb,
                                              logic [DATA_W-1:0] mv,
                                              logic [IMM_W-1:0]  k);
      case (s)
         SRC_RA:  return ra;
         SRC_RB:  return rb;
         SRC_MEM: return mv;
         SRC_IMM: return DATA_W'(k);
         default: return DATA_W'(1);
      endcase
   endfunction

   assign alu_a = pick(ctl.sa, ra_val, rb_val, opnd_q, imm);
   assign alu_b = pick(ctl.sb, ra_val, rb_val, opnd_q, imm);

   mc_cpu_alu #(.W(DATA_W)) u_alu (
      .a   (alu_a),
      .b   (alu_b),
      .op  (ctl.op),
      .res (alu_res),
      .z   (alu_z),
      .c   (alu_c),
      .v   (alu_v)
   );

   always_comb begin
      rf_we    = 1'b0;
      rf_wdata = alu_res;
      if (in_exec && ctl.ex && ctl.wr_reg) begin
         rf_we = 1'b1;
      end else if (in_load && ctl.ld_io) begin
         rf_we    = 1'b1;
         rf_wdata = io_rdata;
      end
   end

   // Instruction register: one variant per fetch beat count.
   if (BEATS == 1) begin : g_ir_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 ir_q <= '0;
         else if (phase == PH_FETCH) ir_q <= mem_rdata[INSTR_W-1:0];
      end
   end else begin : g_ir_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 ir_q <= '0;
         else if (phase == PH_FETCH) ir_q <= {ir_q[INSTR_W-DATA_W-1:0], mem_rdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q  <= '0;
         res_q   <= '0;
         flags_q <= '0;
      end else begin
         if (in_load && ctl.ld_mem) opnd_q <= mem_rdata;
         if (in_exec && ctl.ex) begin
            res_q   <= alu_res;
            flags_q <= {alu_v, alu_c, alu_z};
         end
      end
   end

   assign ld_addr   = ctl.ld_rb ? rb_val[ADDR_W-1:0] : imm;
   assign mem_rd    = (phase == PH_FETCH) || (in_load && ctl.ld_mem);
   assign mem_wr    = in_store && ctl.st_mem;
   assign mem_addr  = (phase == PH_FETCH) ? pc : (in_store ? imm : ld_addr);
   assign mem_wdata = res_q;
   assign io_rd     = in_load && ctl.ld_io;
   assign io_wr     = in_store && ctl.st_io;
   assign io_addr   = imm;
   assign io_wdata  = ra_val;
   assign flags_o   = flags_q;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, io_rd, io_wr})); // R10

   AST_FLAGS_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_EXEC) |=> $stable(flags_q)); // R9

   AST_WRITE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(phase) == PH_EXEC)); // R8

   AST_PORT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd || io_wr) |-> (!mem_rd && !mem_wr)); // R10

endmodule

// File: tb/mc_cpu_core_tb.sv
`timescale 1ns/1ps
module mc_cpu_core_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] mem_addr, io_addr;
   logic       mem_rd, mem_wr, io_rd, io_wr;
   logic [7:0] mem_wdata, mem_rdata, io_wdata, io_rdata;
   logic [2:0] flags_o;

   always #4 clk = ~clk;

   mc_cpu_core u_dut (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .flags_o(flags_o)
   );

   logic [7:0] mem [64];
   assign mem_rdata = mem[mem_addr];
   assign io_rdata  = {io_addr, 2'b01} ^ 8'h5A;
   always @(posedge clk) if (rst_n && mem_wr) mem[mem_addr] <= mem_wdata;

   int checks = 0;
   int errors = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct {
      bit rd, wr, ird, iwr;
      int addr, wdata, ioaddr, iowdata, flags;
      string tag;
   } exp_t;

   exp_t     expq[$];
   int       mreg[4];
   int       mpc;
   int       mflags;
   int       mmem[64];
   int       outs_port[$];
   int       outs_val[$];

   function automatic int port_val(int p);
      return ((p * 4) + 1) ^ 8'h5A;
   endfunction

   function automatic int alu_m(bit sub, int a, int b, output int f);
      int r, sa, sb, sr, c, v, z;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      if (sub) begin r = a - b; c = (a < b); sr = sa - sb; end
      else     begin r = a + b; c = (r > 255); sr = sa + sb; end
      v = (sr > 127 || sr < -128);
      r = r & 255;
      z = (r == 0);
      f = v * 4 + c * 2 + z;
      return r;
   endfunction

   task automatic push(string tag, bit rd, bit wr, bit ird, bit iwr,
                       int addr, int wdata, int ioaddr, int iowdata);
      exp_t e;
      e.rd = rd; e.wr = wr; e.ird = ird; e.iwr = iwr;
      e.addr = addr; e.wdata = wdata; e.ioaddr = ioaddr; e.iowdata = iowdata;
      e.flags = mflags; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic gen_instr();
      int ir = 0;
      int op, a, b, k, v, r, f;
      for (int bt = 0; bt < 2; bt++) begin
         push("R2", 1, 0, 0, 0, mpc, 0, 0, 0);
         ir = ((ir << 8) | mmem[mpc]) & 16'hFFFF;
         mpc = (mpc + 1) % 64;
      end
      op = ir >> 10; a = (ir >> 8) & 3; b = (ir >> 6) & 3; k = ir & 63;
      push((op == 0 || op > 11) ? "R4" : "R3", 0, 0, 0, 0, 0, 0, 0, 0);
      case (op)
         1: begin push("R5", 0,0,0,0, 0,0,0,0); mreg[a] = alu_m(0, mreg[a], 1, f); mflags = f; end
         2: begin push("R5", 0,0,0,0, 0,0,0,0); mreg[a] = alu_m(0, mreg[a], mreg[b], f); mflags = f; end
         3: begin push("R5", 0,0,0,0, 0,0,0,0); mreg[a] = alu_m(1, mreg[b], mreg[a], f); mflags = f; end
         4, 5: begin
            push("R6", 1,0,0,0, mreg[b] % 64, 0,0,0);
            v = mmem[mreg[b] % 64];
            push("R6", 0,0,0,0, 0,0,0,0);
            if (op == 4) mreg[a] = alu_m(0, mreg[a], v, f);
            else         mreg[a] = alu_m(1, v, mreg[a], f);
            mflags = f;
         end
         6: begin
            push("R8", 1,0,0,0, k, 0,0,0);
            v = mmem[k];
            push("R8", 0,0,0,0, 0,0,0,0);
            r = alu_m(0, v, 1, f); mflags = f;
            push("R8", 0,1,0,0, k, r, 0,0);
            mmem[k] = r;
         end
         7: begin push("R7", 0,0,0,0, 0,0,0,0); mreg[a] = alu_m(0, mreg[a], k, f); mflags = f; end
         8: begin push("R7", 0,0,0,0, 0,0,0,0); mreg[a] = alu_m(1, k, mreg[a], f); mflags = f; end
         9: begin
            push("R8", 1,0,0,0, k, 0,0,0);
            v = mmem[k];
            push("R8", 0,0,0,0, 0,0,0,0);
            mreg[a] = alu_m(0, mreg[a], v, f); mflags = f;
         end
         10: begin push("R10", 0,0,1,0, 0,0,k,0); mreg[a] = port_val(k); end
         11: push("R10", 0,0,0,1, 0,0,k,mreg[a]);
         default: ;
      endcase
   endtask

   task automatic compare_cycle();
      exp_t e;
      if (expq.size() == 0) gen_instr();
      e = expq.pop_front();
      chk(e.tag, "strobes", {mem_rd, mem_wr, io_rd, io_wr}, {e.rd, e.wr, e.ird, e.iwr});
      if (e.rd || e.wr) chk(e.tag, "mem_addr", mem_addr, e.addr);
      if (e.wr)         chk(e.tag, "mem_wdata", mem_wdata, e.wdata);
      if (e.ird || e.iwr) chk(e.tag, "io_addr", io_addr, e.ioaddr);
      if (e.iwr)        chk(e.tag, "io_wdata", io_wdata, e.iowdata);
      chk("R9", "flags", flags_o, e.flags);
      if (io_wr) begin outs_port.push_back(io_addr); outs_val.push_back(io_wdata); end
   endtask

   task automatic run_prog(int ncyc);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "reset flags", flags_o, 0);
      chk("R1", "reset strobes", {mem_wr, io_rd, io_wr}, 0);
      chk("R1", "reset fetch addr", mem_addr, 0);
      for (int i = 0; i < 64; i++) mmem[i] = mem[i];
      for (int i = 0; i < 4; i++) mreg[i] = 0;
      mpc = 0; mflags = 0;
      expq.delete(); outs_port.delete(); outs_val.delete();
      rst_n = 1'b1;
      #1;
      for (int c = 0; c < ncyc; c++) begin
         compare_cycle();
         @(negedge clk);
         #1;
      end
   endtask

   // ---------------- programs ----------------
   task automatic put(int idx, int op, int a, int b, int k);
      int w;
      w = (op << 10) | (a << 8) | (b << 6) | k;
      mem[2*idx]   = 8'(w >> 8);
      mem[2*idx+1] = 8'(w);
   endtask

   task automatic load_directed();
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      put(0, 7, 0, 0, 5);      // R0 = 5
      put(1, 7, 1, 0, 3);      // R1 = 3
      put(2, 2, 0, 1, 0);      // R0 = 8
      put(3, 11, 0, 0, 1);     // out port1 = 8
      put(4, 3, 1, 0, 0);      // R1 = R0 - R1 = 5
      put(5, 11, 1, 0, 2);     // out port2 = 5
      put(6, 8, 2, 0, 0);      // R2 = 0 - R2 = 0, Z
      put(7, 7, 2, 0, 6'h30);  // R2 = 0x30
      put(8, 4, 3, 2, 0);      // R3 = 0 + mem[0x30] = 0x7F
      put(9, 1, 3, 0, 0);      // R3 = 0x80, V
      put(10, 11, 3, 0, 3);    // out port3 = 0x80
      put(11, 6, 0, 0, 6'h31); // mem[0x31] 0xFF -> 0x00, Z C
      put(12, 9, 1, 0, 6'h31); // R1 = 5 + 0
      put(13, 10, 2, 0, 9);    // R2 = port 9 = 0x7F
      put(14, 11, 2, 0, 4);    // out port4 = 0x7F
      put(15, 63, 3, 3, 6'h3F);// undefined opcode
      put(16, 0, 0, 0, 0);     // NOP
      put(17, 8, 1, 0, 2);     // R1 = 2 - 5 = 0xFD, C
      put(18, 11, 1, 0, 5);    // out port5 = 0xFD
      mem[6'h30] = 8'h7F;
      mem[6'h31] = 8'hFF;
   endtask

   task automatic check_directed(string tag);
      int ep[5] = '{1, 2, 3, 4, 5};
      int ev[5] = '{8'h08, 8'h05, 8'h80, 8'h7F, 8'hFD};
      chk(tag, "port writes seen", (outs_port.size() >= 5), 1);
      for (int i = 0; i < 5 && i < outs_port.size(); i++) begin
         chk(tag, "out port", outs_port[i], ep[i]);
         chk(tag, "out value", outs_val[i], ev[i]);
      end
      chk("R8", "mem[0x31] after increment", mem[6'h31], 0);
      chk("R6", "mem[0x30] unchanged", mem[6'h30], 8'h7F);
   endtask

   task automatic load_random(int seed);
      int s = seed;
      for (int i = 0; i < 64; i += 2) begin
         int op;
         s = s * 1103515245 + 12345;
         op = ((s >>> 16) & 32'h7FFF) % 14;
         if (op > 11) op = 6'h2A;
         s = s * 1103515245 + 12345;
         mem[i]   = 8'((op << 2) | ((s >>> 16) & 3));
         mem[i+1] = 8'(s >>> 20);
      end
   endtask

   initial begin
      load_directed();
      run_prog(110);
      check_directed("R5");
      load_directed();
      run_prog(110);          // second pass: registers must start cleared (R1)
      check_directed("R1");
      for (int sd = 1; sd <= 3; sd++) begin
         load_random(sd * 7919);
         run_prog(1500);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule